// File: doc/BRIEF.md
# Left-to-Right Operand Bus Fabric with Feedback Registers

This block is the word-wide switch fabric of a coarse-grained compute column. A row of subblock slots (multipliers, adders, general word logic) sits along a one-way bus. Each slot gets two operands, A and B. Each operand comes from a bus-wide multiplexer that may choose an external input bus, a feedback register, or the registered output of a slot further left. The fabric owns the output register of every slot. The subblock computes a result on the operand ports, and control logic outside the block decides through a write enable when that result is captured.

Data can move right to left in only one way: through a small bank of feedback registers. Each feedback register captures the registered output of a configured slot when its load enable is high, so a slot can use a value computed further right one cycle later. This is the path for accumulation loops. Output buses each pick one slot register or feedback register and are combinational from those registers.

All multiplexer selects are small index fields held in a configuration store. Software or a loader writes the store one field per cycle through a synchronous port. A reset clears every field to select index 0.

Top module: `bus_fabric`

## Requirements
- R1: After reset, every slot output register, every feedback register and every configuration field is zero. As a result, both operands of every slot equal input bus 0 and every output bus is zero.
- R2: An operand select value v for slot k has this meaning. For v < N_IN it picks input bus v. For N_IN <= v < N_IN+N_FB it picks feedback register v-N_IN. For N_IN+N_FB <= v < N_IN+N_FB+k it picks the output register of slot v-N_IN-N_FB.
- R3: An operand select value of N_IN+N_FB+k or more drives zero onto that operand of slot k. A slot therefore never sees its own output register or the output register of any slot to its right.
- R4: On a rising edge with slot_we[k] high, the output register of slot k loads slot_res word k. With slot_we[k] low it keeps its value, whatever slot_res carries.
- R5: On a rising edge with fb_load[f] high, feedback register f loads the output register of the slot named by its source field. A source value of N_SLOT or more loads zero. With fb_load[f] low the register keeps its value.
- R6: Output bus o shows slot register v for v < N_SLOT, and feedback register v-N_SLOT for N_SLOT <= v < N_SLOT+N_FB. Any larger select value gives zero. The output is combinational from those registers.
- R7: Configuration field addresses are laid out as follows. Operand A of slot k is at address 2k. Operand B of slot k is at 2k+1. The source of feedback register f is at 2*N_SLOT+f. The select of output bus o is at 2*N_SLOT+N_FB+o. A write to an address of 2*N_SLOT+N_FB+N_OUT or more changes no field.
- R8: A configuration write with cfg_we high takes effect at the rising edge. The muxes use the old value up to that edge and the new value after it.
- R9: A slot that takes a feedback register as one operand and an input bus as the other can form a running sum with its own output through that feedback register. With an increment of 1 and both enables held high from zero, the sum reaches n after 2n cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration field write strobe |
| cfg_addr | input | AW | Configuration field address |
| cfg_wdata | input | SELW | Select value to write |
| in_bus | input | N_IN*W | External input buses, bus i at bits i*W upward |
| slot_res | input | N_SLOT*W | Subblock results, word k from slot k |
| slot_we | input | N_SLOT | Per-slot output register write enable |
| fb_load | input | N_FB | Per-feedback-register load enable |
| opnd_a | output | N_SLOT*W | Operand A for each slot |
| opnd_b | output | N_SLOT*W | Operand B for each slot |
| out_bus | output | N_OUT*W | Output buses |

## Verification
A corrupted slot register or feedback register shows up at once on any operand or output bus that selects it. It appears in the same cycle after the faulty edge, so every check compares all operand and output words against a bench model each cycle. A wrong configuration field also shows up one edge after the write, as a wrong source on the mux it controls. Random configuration writes also hit the unused addresses, so a decoder that aliases them breaks a live mux within a cycle. A broken left-only limit shows up as a nonzero operand where zero is expected. A broken feedback path shows up as a wrong running sum after a known number of cycles.

// File: rtl/fabric_pkg.sv
package fabric_pkg;

    localparam int DEF_W     = 32;
    localparam int DEF_SLOTS = 9;
    localparam int DEF_INS   = 4;
    localparam int DEF_OUTS  = 3;
    localparam int DEF_FBS   = 3;

    typedef enum logic {
        OPND_A = 1'b0,
        OPND_B = 1'b1
    } opnd_port_e;

    // Configuration field address layout.
    function automatic int opnd_field(int slot, int which);
        return 2 * slot + which;
    endfunction

    function automatic int fb_field(int n_slot, int f);
        return 2 * n_slot + f;
    endfunction

    function automatic int out_field(int n_slot, int n_fb, int o);
        return 2 * n_slot + n_fb + o;
    endfunction

    function automatic int field_count(int n_slot, int n_fb, int n_out);
        return 2 * n_slot + n_fb + n_out;
    endfunction

endpackage

// File: rtl/fabric_sel_mux.sv
module fabric_sel_mux #(
    parameter int W     = 32,
    parameter int SELW  = 4,
    parameter int NSRC  = 16,
    parameter int LIMIT = 16
) (
    input  logic [SELW-1:0]          sel,
    input  logic [NSRC-1:0][W-1:0]   src,
    output logic [W-1:0]             y
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [SELW:0] LIM = LIMIT[SELW:0];

    // Selects at or past LIMIT are not routable here and drive zero.
    always_comb begin
        y = '0;
        if ({1'b0, sel} < LIM) begin
            y = src[sel[IW-1:0]];
        end
    end
endmodule

// File: rtl/fabric_cfg_store.sv
module fabric_cfg_store #(
    parameter int NFIELD = 24,
    parameter int SELW   = 4,
    parameter int AW     = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  logic [SELW-1:0]               wdata,
    output logic [NFIELD-1:0][SELW-1:0]   fields
);
    localparam logic [AW-1:0] NF = NFIELD[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            fields <= '0;
        end else if (we && (addr < NF)) begin
            fields[addr] <= wdata;
        end
    end
endmodule

// File: rtl/fabric_slot_regs.sv
module fabric_slot_regs #(
    parameter int W      = 32,
    parameter int N_SLOT = 9
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_SLOT-1:0]            we,
    input  logic [N_SLOT-1:0][W-1:0]     res,
    output logic [N_SLOT-1:0][W-1:0]     q
);
    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
        logic [W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (we[k]) begin
                word_q <= res[k];
            end
        end
        assign q[k] = word_q;
    end
endmodule

// File: rtl/fabric_fb_bank.sv
module fabric_fb_bank #(
    parameter int W      = 32,
    parameter int N_SLOT = 9,
    parameter int N_FB   = 3,
    parameter int SELW   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_FB-1:0]              load,
    input  logic [N_FB-1:0][SELW-1:0]    sel,
    input  logic [N_SLOT-1:0][W-1:0]     slot_q,
    output logic [N_FB-1:0][W-1:0]       fb_q
);
    for (genvar f = 0; f < N_FB; f++) begin : g_fb
        logic [W-1:0] pick;
        logic [W-1:0] word_q;

        fabric_sel_mux #(
            .W(W), .SELW(SELW), .NSRC(N_SLOT), .LIMIT(N_SLOT)
        ) src_mux (
            .sel(sel[f]), .src(slot_q), .y(pick)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (load[f]) begin
                word_q <= pick;
            end
        end
        assign fb_q[f] = word_q;
    end
endmodule

// File: rtl/bus_fabric.sv
module bus_fabric
    import fabric_pkg::*;
#(
    parameter int W      = DEF_W,
    parameter int N_SLOT = DEF_SLOTS,
    parameter int N_IN   = DEF_INS,
    parameter int N_OUT  = DEF_OUTS,
    parameter int N_FB   = DEF_FBS,
    localparam int NSRC   = N_IN + N_FB + N_SLOT,
    localparam int SELW   = $clog2(NSRC),
    localparam int NFIELD = field_count(N_SLOT, N_FB, N_OUT),
    localparam int AW     = $clog2(NFIELD + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [SELW-1:0]        cfg_wdata,
    input  logic [N_IN*W-1:0]      in_bus,
    input  logic [N_SLOT*W-1:0]    slot_res,
    input  logic [N_SLOT-1:0]      slot_we,
    input  logic [N_FB-1:0]        fb_load,
    output logic [N_SLOT*W-1:0]    opnd_a,
    output logic [N_SLOT*W-1:0]    opnd_b,
    output logic [N_OUT*W-1:0]     out_bus
);
    localparam int NOSRC = N_SLOT + N_FB;

    logic [NFIELD-1:0][SELW-1:0]  cfg_q;
    logic [N_SLOT-1:0][W-1:0]     slot_res_w;
    logic [N_SLOT-1:0][W-1:0]     slot_q;
    logic [N_FB-1:0][W-1:0]       fb_q;
    logic [N_FB-1:0][SELW-1:0]    fb_sel;
    logic [NSRC-1:0][W-1:0]       src_all;
    logic [NOSRC-1:0][W-1:0]      out_src;

    assign slot_res_w = slot_res;

    fabric_cfg_store #(.NFIELD(NFIELD), .SELW(SELW), .AW(AW)) cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .fields(cfg_q)
    );

    fabric_slot_regs #(.W(W), .N_SLOT(N_SLOT)) slots_i (
        .clk(clk), .rst(rst), .we(slot_we), .res(slot_res_w), .q(slot_q)
    );

    for (genvar f = 0; f < N_FB; f++) begin : g_fbsel
        assign fb_sel[f] = cfg_q[fb_field(N_SLOT, f)];
    end

    fabric_fb_bank #(.W(W), .N_SLOT(N_SLOT), .N_FB(N_FB), .SELW(SELW)) fb_i (
        .clk(clk), .rst(rst), .load(fb_load), .sel(fb_sel),
        .slot_q(slot_q), .fb_q(fb_q)
    );

    // Shared operand source list: input buses, feedback, slot registers.
    for (genvar i = 0; i < N_IN; i++) begin : g_src_in
        assign src_all[i] = in_bus[i*W +: W];
    end
    for (genvar f = 0; f < N_FB; f++) begin : g_src_fb
        assign src_all[N_IN+f] = fb_q[f];
    end
    for (genvar k = 0; k < N_SLOT; k++) begin : g_src_slot
        assign src_all[N_IN+N_FB+k] = slot_q[k];
    end

    // Slot k may only reach sources below N_IN+N_FB+k.
    for (genvar k = 0; k < N_SLOT; k++) begin : g_opnd
        fabric_sel_mux #(
            .W(W), .SELW(SELW), .NSRC(NSRC), .LIMIT(N_IN + N_FB + k)
        ) mux_a (
            .sel(cfg_q[opnd_field(k, int'(OPND_A))]), .src(src_all),
            .y(opnd_a[k*W +: W])
        );
        fabric_sel_mux #(
            .W(W), .SELW(SELW), .NSRC(NSRC), .LIMIT(N_IN + N_FB + k)
        ) mux_b (
            .sel(cfg_q[opnd_field(k, int'(OPND_B))]), .src(src_all),
            .y(opnd_b[k*W +: W])
        );
    end

    // Output source list: slot registers, then feedback registers.
    for (genvar k = 0; k < N_SLOT; k++) begin : g_osrc_slot
        assign out_src[k] = slot_q[k];
    end
    for (genvar f = 0; f < N_FB; f++) begin : g_osrc_fb
        assign out_src[N_SLOT+f] = fb_q[f];
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        fabric_sel_mux #(
            .W(W), .SELW(SELW), .NSRC(NOSRC), .LIMIT(NOSRC)
        ) mux_o (
            .sel(cfg_q[out_field(N_SLOT, N_FB, o)]), .src(out_src),
            .y(out_bus[o*W +: W])
        );
    end
endmodule

// File: rtl/bus_fabric_chk.sv
module bus_fabric_chk
    import fabric_pkg::*;
#(
    parameter int W      = 32,
    parameter int N_SLOT = 9,
    parameter int N_IN   = 4,
    parameter int N_OUT  = 3,
    parameter int N_FB   = 3,
    parameter int NFIELD = 24,
    parameter int SELW   = 4,
    parameter int AW     = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic [N_SLOT-1:0]            slot_we,
    input logic [N_SLOT*W-1:0]          slot_res,
    input logic [N_SLOT-1:0][W-1:0]     slot_q,
    input logic [N_FB-1:0]              fb_load,
    input logic [N_FB-1:0][W-1:0]       fb_q,
    input logic                         cfg_we,
    input logic [AW-1:0]                cfg_addr,
    input logic [NFIELD-1:0][SELW-1:0]  cfg_q,
    input logic [N_SLOT*W-1:0]          opnd_a,
    input logic [N_SLOT*W-1:0]          opnd_b,
    input logic [N_OUT*W-1:0]           out_bus
);
    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot_chk
        // R4
        slot_load_chk: assert property (@(posedge clk) disable iff (rst)
            slot_we[k] |=> slot_q[k] == $past(slot_res[k*W +: W]));
        // R4
        slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !slot_we[k] |=> $stable(slot_q[k]));
        // R3
        left_only_a_chk: assert property (@(posedge clk) disable iff (rst)
            int'(cfg_q[opnd_field(k, 0)]) >= N_IN + N_FB + k
            |-> opnd_a[k*W +: W] == '0);
        // R3
        left_only_b_chk: assert property (@(posedge clk) disable iff (rst)
            int'(cfg_q[opnd_field(k, 1)]) >= N_IN + N_FB + k
            |-> opnd_b[k*W +: W] == '0);
    end

    for (genvar f = 0; f < N_FB; f++) begin : g_fb_chk
        // R5
        fb_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !fb_load[f] |=> $stable(fb_q[f]));
        // R5
        fb_zero_chk: assert property (@(posedge clk) disable iff (rst)
            fb_load[f] && int'(cfg_q[fb_field(N_SLOT, f)]) >= N_SLOT
            |=> fb_q[f] == '0);
        // R5
        fb_take_chk: assert property (@(posedge clk) disable iff (rst)
            fb_load[f] && int'(cfg_q[fb_field(N_SLOT, f)]) < N_SLOT
            |=> fb_q[f] == $past(slot_q[cfg_q[fb_field(N_SLOT, f)]]));
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
        // R6
        out_range_chk: assert property (@(posedge clk) disable iff (rst)
            int'(cfg_q[out_field(N_SLOT, N_FB, o)]) >= N_SLOT + N_FB
            |-> out_bus[o*W +: W] == '0);
    end

    // R7
    cfg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && int'(cfg_addr) >= NFIELD |=> $stable(cfg_q));
endmodule

bind bus_fabric bus_fabric_chk #(
    .W(W), .N_SLOT(N_SLOT), .N_IN(N_IN), .N_OUT(N_OUT), .N_FB(N_FB),
    .NFIELD(NFIELD), .SELW(SELW), .AW(AW)
) chk_i (
    .clk(clk), .rst(rst), .slot_we(slot_we), .slot_res(slot_res),
    .slot_q(slot_q), .fb_load(fb_load), .fb_q(fb_q), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_q(cfg_q), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_bus(out_bus)
);

// File: tb/bus_fabric_tb_top.sv
`timescale 1ns/1ps
module bus_fabric_tb_top;
    import fabric_pkg::*;

    localparam int W      = 32;
    localparam int N_SLOT = 9;
    localparam int N_IN   = 4;
    localparam int N_OUT  = 3;
    localparam int N_FB   = 3;
    localparam int NSRC   = N_IN + N_FB + N_SLOT;
    localparam int SELW   = $clog2(NSRC);
    localparam int NFIELD = field_count(N_SLOT, N_FB, N_OUT);
    localparam int AW     = $clog2(NFIELD + 1);

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 cfg_we;
    logic [AW-1:0]        cfg_addr;
    logic [SELW-1:0]      cfg_wdata;
    logic [N_IN*W-1:0]    in_bus;
    logic [N_SLOT*W-1:0]  slot_res;
    logic [N_SLOT-1:0]    slot_we;
    logic [N_FB-1:0]      fb_load;
    logic [N_SLOT*W-1:0]  opnd_a;
    logic [N_SLOT*W-1:0]  opnd_b;
    logic [N_OUT*W-1:0]   out_bus;

    bus_fabric #(.W(W), .N_SLOT(N_SLOT), .N_IN(N_IN), .N_OUT(N_OUT),
                 .N_FB(N_FB)) dut_i (.*);

    always #2.5 clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    logic [W-1:0] m_slot [N_SLOT];
    logic [W-1:0] m_fb   [N_FB];
    int           m_cfg  [NFIELD];

    function automatic logic [W-1:0] src_word(int idx);
        if (idx < N_IN) return in_bus[idx*W +: W];
        if (idx < N_IN + N_FB) return m_fb[idx-N_IN];
        return m_slot[idx-N_IN-N_FB];
    endfunction

    function automatic logic [W-1:0] exp_opnd(int k, int which);
        int sel = m_cfg[opnd_field(k, which)];
        if (sel < N_IN + N_FB + k) return src_word(sel);
        return '0;
    endfunction

    function automatic logic [W-1:0] exp_out(int o);
        int sel = m_cfg[out_field(N_SLOT, N_FB, o)];
        if (sel < N_SLOT) return m_slot[sel];
        if (sel < N_SLOT + N_FB) return m_fb[sel-N_SLOT];
        return '0;
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act,
                         logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        for (int k = 0; k < N_SLOT; k++) begin
            for (int b = 0; b < 2; b++) begin
                int sel = m_cfg[opnd_field(k, b)];
                string tag = (sel < N_IN + N_FB + k) ? "R2" : "R3";
                logic [W-1:0] act = b ? opnd_b[k*W +: W] : opnd_a[k*W +: W];
                check(tag, $sformatf("slot %0d operand %0d", k, b), act,
                      exp_opnd(k, b));
            end
        end
        for (int o = 0; o < N_OUT; o++) begin
            int sel = m_cfg[out_field(N_SLOT, N_FB, o)];
            string tag = (sel < N_SLOT) ? "R4" :
                         (sel < N_SLOT + N_FB) ? "R5" : "R6";
            check(tag, $sformatf("output bus %0d", o), out_bus[o*W +: W],
                  exp_out(o));
        end
    endtask

    // Rising edge, model update, then back to the falling edge.
    task automatic advance();
        logic [W-1:0] nslot [N_SLOT];
        logic [W-1:0] nfb   [N_FB];
        @(posedge clk);
        for (int k = 0; k < N_SLOT; k++)
            nslot[k] = slot_we[k] ? slot_res[k*W +: W] : m_slot[k];
        for (int f = 0; f < N_FB; f++) begin
            int sel = m_cfg[fb_field(N_SLOT, f)];
            nfb[f] = !fb_load[f] ? m_fb[f] :
                     (sel < N_SLOT) ? m_slot[sel] : '0;
        end
        if (rst) begin
            for (int k = 0; k < N_SLOT; k++) m_slot[k] = '0;
            for (int f = 0; f < N_FB; f++) m_fb[f] = '0;
            for (int i = 0; i < NFIELD; i++) m_cfg[i] = 0;
        end else begin
            for (int k = 0; k < N_SLOT; k++) m_slot[k] = nslot[k];
            for (int f = 0; f < N_FB; f++) m_fb[f] = nfb[f];
            if (cfg_we && int'(cfg_addr) < NFIELD)
                m_cfg[int'(cfg_addr)] = int'(cfg_wdata);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_we  = 1'b0;
        slot_we = '0;
        fb_load = '0;
    endtask

    task automatic cfg_write(int addr, int val);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(addr);
        cfg_wdata = SELW'(val);
        advance();
        cfg_we    = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        for (int i = 0; i < 3; i++) advance();
        rst = 1'b0;
    endtask

    task automatic drive_random();
        for (int i = 0; i < N_IN; i++) in_bus[i*W +: W] = $urandom;
        for (int k = 0; k < N_SLOT; k++) slot_res[k*W +: W] = $urandom;
        slot_we   = N_SLOT'($urandom);
        fb_load   = N_FB'($urandom);
        cfg_we    = ($urandom % 4) == 0;
        cfg_addr  = AW'($urandom);
        cfg_wdata = SELW'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        cfg_addr = '0; cfg_wdata = '0; slot_res = '0;
        for (int i = 0; i < N_IN; i++) in_bus[i*W +: W] = 32'h1000 + i;
        @(negedge clk);
        do_reset();

        // R1: reset state seen at the ports
        #1;
        for (int k = 0; k < N_SLOT; k++) begin
            check("R1", "operand A after reset", opnd_a[k*W +: W], 32'h1000);
            check("R1", "operand B after reset", opnd_b[k*W +: W], 32'h1000);
        end
        for (int o = 0; o < N_OUT; o++)
            check("R1", "output after reset", out_bus[o*W +: W], '0);

        // R8: write lands at the edge, not before
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(opnd_field(3, 0)); cfg_wdata = SELW'(1);
        #1 check("R8", "slot 3 A before edge", opnd_a[3*W +: W], 32'h1000);
        @(negedge clk);
        advance();
        cfg_we = 1'b0;
        #1 check("R8", "slot 3 A after edge", opnd_a[3*W +: W], 32'h1001);

        // R7: unused addresses change nothing
        for (int a = NFIELD; a < (1 << AW); a++) begin
            cfg_write(a, $urandom);
            #1 check("R7", "slot 3 A after unused-address write",
                     opnd_a[3*W +: W], 32'h1001);
            check_all();
        end

        // R3, R2, R5, R6 directed corners
        cfg_write(opnd_field(0, 0), N_IN + N_FB);
        cfg_write(opnd_field(8, 1), NSRC - 1);
        cfg_write(opnd_field(8, 0), NSRC - 2);
        cfg_write(out_field(N_SLOT, N_FB, 2), (1 << SELW) - 1);
        cfg_write(out_field(N_SLOT, N_FB, 0), N_SLOT);
        cfg_write(out_field(N_SLOT, N_FB, 1), 7);
        cfg_write(fb_field(N_SLOT, 0), 7);
        slot_res[7*W +: W] = 32'hABCD_0007;
        slot_we = '0; slot_we[7] = 1'b1;
        advance();
        slot_we = '0; fb_load[0] = 1'b1;
        advance();
        fb_load = '0;
        #1;
        check("R3", "slot 0 A picks itself", opnd_a[0*W +: W], '0);
        check("R3", "slot 8 B picks itself", opnd_b[8*W +: W], '0);
        check("R2", "slot 8 A picks slot 7", opnd_a[8*W +: W], 32'hABCD_0007);
        check("R5", "out 0 shows feedback 0", out_bus[0*W +: W], 32'hABCD_0007);
        check("R6", "out 2 out-of-range", out_bus[2*W +: W], '0);
        check_all();
        // R4: result changes with enable low do not load
        slot_res[7*W +: W] = 32'h5555_AAAA;
        advance();
        #1 check("R4", "slot 7 holds with enable low", out_bus[1*W +: W],
                 32'hABCD_0007);
        // R5: feedback source past range loads zero
        cfg_write(fb_field(N_SLOT, 0), N_SLOT + 2);
        fb_load[0] = 1'b1;
        advance();
        fb_load = '0;
        #1 check("R5", "feedback from invalid source", out_bus[0*W +: W], '0);

        // R9: running sum through feedback register 0
        do_reset();
        cfg_write(opnd_field(1, 0), N_IN);
        cfg_write(opnd_field(1, 1), 0);
        cfg_write(fb_field(N_SLOT, 0), 1);
        cfg_write(out_field(N_SLOT, N_FB, 0), 1);
        for (int i = 0; i < N_IN; i++) in_bus[i*W +: W] = '0;
        in_bus[0 +: W] = 32'd1;
        for (int c = 0; c < 20; c++) begin
            slot_we = '0; slot_we[1] = 1'b1;
            fb_load = '0; fb_load[0] = 1'b1;
            slot_res[1*W +: W] = exp_opnd(1, 0) + exp_opnd(1, 1);
            #1 check_all();
            advance();
        end
        idle();
        #1 check("R9", "running sum after 20 cycles", out_bus[0*W +: W], 32'd10);

        // Random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            drive_random();
            #1 check_all();
            advance();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end
endmodule